// File: doc/BRIEF.md
# Data-Dependent Iterative Multiplier

This block multiplies two W-bit words and returns the low W bits of the product. It works through the second operand (the multiplier) in radix-4 steps: each iteration consumes two multiplier bits, adds the matching multiple of the first operand (the multiplicand) to an accumulator, then moves on. As soon as the unconsumed multiplier bits are all zero the loop ends, so small multipliers finish early.

A caller raises `start_i` with both operands while `busy_o` is low. `busy_o` stays high while the operation runs. `done_o` then pulses for one cycle, carrying the product on `prod_o` and the total latency on `cycles_o`. The latency is a fixed overhead of three cycles plus one cycle per radix-4 iteration. A scheduler can therefore check or model the timing from `cycles_o`.

Top module: `iter_mult`

## Requirements
- R1: After a synchronous reset, `busy_o` and `done_o` are low until a start is accepted.
- R2: When `done_o` is high, `prod_o` equals the low W bits of `dst_i * src_i` as sampled at the accepting edge.
- R3: The number of iterations k is the number of 2-bit right shifts needed to bring `src_i` to zero. Counting the accepting edge as edge 1, `done_o` rises at edge 3+k.
- R4: A zero multiplier needs no iterations. It completes at edge 3 with a zero product.
- R5: With W=32, any multiplier with bit 31 or bit 30 set takes 16 iterations, for 19 cycles in total.
- R6: `busy_o` is high from the accepting edge until the edge at which `done_o` rises. It is low while `done_o` is high.
- R7: A `start_i` that arrives while `busy_o` is high has no effect: the running operation's product and timing are unchanged, and no extra result follows.
- R8: `done_o` is high for exactly one cycle per accepted start. During that cycle `cycles_o` equals the latency defined in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request; accepted only when not busy |
| dst_i | input | W | Multiplicand operand |
| src_i | input | W | Multiplier operand, consumed two bits per iteration |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| prod_o | output | W | Low W bits of the product, valid with `done_o` |
| cycles_o | output | CW | Latency in cycles of the finished operation |

## Verification
A corrupted accumulator or a misaligned multiplicand shift shows up as a wrong `prod_o` on the very next result strobe. A faulty zero test on the remaining multiplier moves the `done_o` edge by one or more cycles, and a broken iteration counter makes `cycles_o` disagree with the measured latency. The sweep covers every multiplier bit length from 0 to 32. Because of this, an off-by-one in the loop exit or in the digit selection is exposed within a single operation of at most 19 cycles.

// File: rtl/imul_pkg.sv
package imul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } imul_state_e;

  localparam int FIXED_CYCLES = 3;
endpackage

// File: rtl/imul_digit_acc.sv
// Adds multiplicand * digit to the accumulator; one shifted term per digit bit.
module imul_digit_acc #(
  parameter int W  = 32,
  parameter int DB = 2
) (
  input  logic [W-1:0]  acc_i,
  input  logic [W-1:0]  mcand_i,
  input  logic [DB-1:0] digit_i,
  output logic [W-1:0]  sum_o
);
  logic [W-1:0] term [DB];

  generate
    for (genvar b = 0; b < DB; b++) begin : g_term
      assign term[b] = digit_i[b] ? (mcand_i << b) : '0;
    end
  endgenerate

  always_comb begin
    sum_o = acc_i;
    for (int b = 0; b < DB; b++) begin
      sum_o = sum_o + term[b];
    end
  end
endmodule

// File: rtl/imul_ctrl.sv
// Sequencer: accept, one preparation cycle, iterations, one finish cycle.
module imul_ctrl
  import imul_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          rem_zero_i,
  input  logic          next_zero_i,
  output logic          load_o,
  output logic          step_o,
  output logic          fin_o,
  output logic          busy_o,
  output logic [IW-1:0] iters_o
);
  imul_state_e state_q, state_d;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign fin_o  = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_PREP;
      ST_PREP: state_d = rem_zero_i ? ST_FIN : ST_RUN;
      ST_RUN:  if (next_zero_i) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_o  <= 1'b0;
      iters_o <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        busy_o  <= 1'b1;
        iters_o <= '0;
      end else if (fin_o) begin
        busy_o  <= 1'b0;
      end
      if (step_o) iters_o <= iters_o + 1'b1;
    end
  end
endmodule

// File: rtl/iter_mult.sv
module iter_mult #(
  parameter  int W        = 32,
  parameter  int DB       = 2,
  localparam int MAX_IT   = (W + DB - 1) / DB,
  localparam int MAX_LAT  = MAX_IT + 3,
  localparam int CW       = $clog2(MAX_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [W-1:0]  dst_i,
  input  logic [W-1:0]  src_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  prod_o,
  output logic [CW-1:0] cycles_o
);
  localparam int IW = $clog2(MAX_IT + 1);

  logic [W-1:0]  acc_q, mcand_q, rem_q, sum;
  logic [W-1:0]  rem_next;
  logic          load, step, fin;
  logic [IW-1:0] iters;

  assign rem_next = rem_q >> DB;

  imul_ctrl #(.IW(IW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rem_zero_i  (rem_q == '0),
    .next_zero_i (rem_next == '0),
    .load_o      (load),
    .step_o      (step),
    .fin_o       (fin),
    .busy_o      (busy_o),
    .iters_o     (iters)
  );

  imul_digit_acc #(.W(W), .DB(DB)) u_acc (
    .acc_i   (acc_q),
    .mcand_i (mcand_q),
    .digit_i (rem_q[DB-1:0]),
    .sum_o   (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      rem_q    <= '0;
      done_o   <= 1'b0;
      prod_o   <= '0;
      cycles_o <= '0;
    end else begin
      done_o <= fin;
      if (load) begin
        acc_q   <= '0;
        mcand_q <= dst_i;
        rem_q   <= src_i;
      end else if (step) begin
        acc_q   <= sum;
        mcand_q <= mcand_q << DB;
        rem_q   <= rem_next;
      end
      if (fin) begin
        prod_o   <= acc_q;
        cycles_o <= CW'(iters) + CW'(imul_pkg::FIXED_CYCLES);
      end
    end
  end
endmodule

// File: rtl/imul_chk.sv
module imul_chk #(
  parameter  int W       = 32,
  parameter  int DB      = 2,
  localparam int MAX_IT  = (W + DB - 1) / DB,
  localparam int MAX_LAT = MAX_IT + 3,
  localparam int CW      = $clog2(MAX_LAT + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] cycles_o
);
  logic [CW:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst) lat_cnt <= '0;
    else if (start_i && !busy_o) lat_cnt <= 1;
    else if (busy_o) lat_cnt <= lat_cnt + 1'b1;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_not_busy_at_done_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  assert_accept_sets_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
  assert_done_follows_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy_o));
  assert_latency_matches_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ({1'b0, cycles_o} == lat_cnt));
  assert_latency_bounds_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cycles_o >= 3 && cycles_o <= MAX_LAT));
endmodule

bind iter_mult imul_chk #(.W(W), .DB(DB)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .cycles_o (cycles_o)
);

// File: tb/iter_mult_tb.sv
module iter_mult_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst, start;
  logic [W-1:0] dst, src, prod;
  logic busy, done;
  logic [CW-1:0] cyc;
  int n_checks = 0;
  int n_fail   = 0;
  int edges    = 0;

  iter_mult u_dut (
    .clk(clk), .rst(rst), .start_i(start), .dst_i(dst), .src_i(src),
    .busy_o(busy), .done_o(done), .prod_o(prod), .cycles_o(cyc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    edges++;
    if (edges > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung (actual %0d edges, expected fewer)", edges);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag, input bit poke);
    logic [W-1:0] expv;
    logic [W-1:0] s;
    int k;
    int n;
    expv = a * b;
    k = 0;
    s = b;
    while (s != 0) begin s = s >> 2; k++; end
    @(negedge clk); start = 1'b1; dst = a; src = b;
    @(posedge clk); n = 1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R6 busy after accept", busy, 1);
    if (poke) begin
      // R7: new request while busy must be ignored
      start = 1'b1; dst = ~a; src = 32'hFFFF_FFFF;
      @(posedge clk); n++;
      @(negedge clk); start = 1'b0;
    end
    while (!done && n < 40) begin
      chk(busy === 1'b1, "R6 busy while running", busy, 1);
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk(busy === 1'b0, "R6 busy low at done", busy, 0);
    chk(prod === expv, {tag, " R2 product"}, prod, expv);
    chk(n == k + 3, {tag, " latency"}, n, k + 3);
    chk(int'(cyc) == n, "R8 cycles_o", cyc, n);
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R8 single-cycle done", done, 0);
    if (poke) begin
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R7 no extra result", {busy, done}, 0);
      end
    end
  endtask

  initial begin
    logic [63:0] mask;
    logic [W-1:0] b;
    logic [W-1:0] avals [3];
    string tag;
    avals[0] = 32'h0000_0001;
    avals[1] = 32'hFFFF_FFFF;
    avals[2] = 32'h9E37_79B9;
    rst = 1'b1; start = 1'b0; dst = '0; src = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chk(done === 1'b0, "R1 done after reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 idle before start", {busy, done}, 0);

    for (int len = 0; len <= 32; len++) begin
      mask = (64'd1 << len) - 1;
      b = (len == 0) ? '0 : W'((64'hA5C3_96E1 | (64'd1 << (len - 1))) & mask);
      tag = (len == 0) ? "R4" : ((len >= 31) ? "R5" : "R3");
      for (int j = 0; j < 3; j++) run_op(avals[j], b, tag, 1'b0);
    end
    run_op(32'h0, 32'h1234_5678, "R2 zero dst", 1'b0);
    run_op(32'hDEAD_BEEF, 32'h4000_0000, "R5", 1'b0);
    run_op(32'hCAFE_F00D, 32'h0000_0003, "R3", 1'b0);
    run_op(32'h1357_9BDF, 32'h0000_00F0, "R7", 1'b1);
    run_op(32'h0000_0007, 32'h0000_0000, "R4", 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule